// File: doc/BRIEF.md
# Divided Clock and Ordered Reset Generator

This block turns one incoming clock and one incoming active-low reset into the clocking and reset set for a small processor core. It produces two clocks. The control clock is the incoming clock inverted. The system clock is a registered divide-by-three of the incoming clock. It also produces a single active-low reset for both domains.

The reset output goes low at the same moment the incoming reset goes low, with no clock needed. Release is ordered. The request first crosses a short synchronizer chain clocked by the control clock. The output then rises only on the control-clock edge that comes half an incoming period before a system-clock rising edge. Logic in both derived domains therefore leaves reset with the same known phase relation every time.

While the incoming reset is low, the divider counter is held at zero. After release, the phase of the system clock is fixed by the moment the incoming reset rises.

Top module: `clkRstGen`

## Requirements
- R1: `ctlClk` is at all times the logical inverse of `extClk`.
- R2: Once running, `sysClk` rises on every third rising edge of `extClk` and stays high for exactly one `extClk` period out of three.
- R3: While `extRstN` is low, `sysRstN` is low and `sysClk` is low. `sysRstN` falls at the moment `extRstN` falls, without waiting for any clock edge.
- R4: When `extRstN` rises between clock edges, the first rising edge of `sysClk` comes on the second rising edge of `extClk` after the release. Later rising edges come every third `extClk` rising edge.
- R5: `sysRstN` rises only on a rising edge of `ctlClk` that falls half an `extClk` period before a `sysClk` rising edge. That edge is no earlier than the third `ctlClk` rising edge after `extRstN` rises, because two synchronizer stages come first.
- R6: Once `extRstN` is high, `sysRstN` rises within SYNC_STAGES + DIV_RATIO rising edges of `ctlClk`, where the defaults are 2 + 3 = 5.
- R7: A reset applied in the middle of operation restarts the whole sequence. The same phase and release timing as in R4 and R5 apply again after the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| extClk | input | 1 | Incoming clock |
| extRstN | input | 1 | Incoming reset, active low, may change at any time |
| ctlClk | output | 1 | Control clock, the inverse of extClk |
| sysClk | output | 1 | System clock, extClk divided by DIV_RATIO |
| sysRstN | output | 1 | Reset for both derived domains, active low, asserts asynchronously and releases in order |

## Verification
Resets are released at random offsets inside both the high and the low half of `extClk`. The two halves give different counts of control edges before release, 5 and 4. A design that ignores which half the release falls in, or that lets go of the reset on the wrong control edge, is caught by this difference. Reset is also applied at random points in the middle of operation and held low for a random length of time. This shows that the assertion is immediate and that the divider phase restarts the same way each time, rather than carrying on from where it stopped. The system clock is checked on both `extClk` edges and across many periods after each release. This tells a correct one-in-three decode apart from off-by-one counter wraps and from a wrong duty cycle.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

  // Strobes decoded from the divider counter and handed to the datapath.
  typedef struct packed {
    logic preRise;  // counter sits on the state just before sysClk rises
    logic wrap;     // counter sits on its last state
  } divStrobe_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import clkrst_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input  logic       extClk,
  input  logic       extRstN,
  output divStrobe_t strobe
);

  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_ST = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] PRE_ST  = CNT_W'(DIV_RATIO - 2);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseNext;

  always_comb begin
    strobe.wrap    = (phaseCnt == LAST_ST);
    strobe.preRise = (phaseCnt == PRE_ST);
    phaseNext      = strobe.wrap ? '0 : phaseCnt + CNT_W'(1);
  end

  // The counter stays at zero while the incoming reset is low.
  always_ff @(posedge extClk or negedge extRstN) begin
    if (!extRstN) phaseCnt <= '0;
    else          phaseCnt <= phaseNext;
  end

  AST_CNT_WRAP: assert property (@(posedge extClk) disable iff (!extRstN)
    (phaseCnt == LAST_ST) |=> (phaseCnt == '0)); // R2

  AST_CNT_RANGE: assert property (@(posedge extClk) disable iff (!extRstN)
    (phaseCnt <= LAST_ST)); // R2

endmodule

// File: rtl/clkRstPath.sv
module clkRstPath
  import clkrst_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       extClk,
  input  logic       extRstN,
  input  divStrobe_t strobe,
  output logic       ctlClk,
  output logic       sysClk,
  output logic       sysRstN
);

  localparam int LAT_MAX = SYNC_STAGES + DIV_RATIO;
  localparam int LAT_W   = $clog2(LAT_MAX + 2);

  logic [SYNC_STAGES-1:0] syncQ;
  logic sysClkQ;
  logic relQ;

  assign ctlClk = ~extClk;

  // System clock: a register loaded from the counter decode, so it has no glitches.
  always_ff @(posedge extClk or negedge extRstN) begin
    if (!extRstN) sysClkQ <= 1'b0;
    else          sysClkQ <= strobe.preRise;
  end

  // Synchronizer chain on the control clock, cleared asynchronously.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge ctlClk or negedge extRstN) begin
          if (!extRstN) syncQ[0] <= 1'b0;
          else          syncQ[0] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge ctlClk or negedge extRstN) begin
          if (!extRstN) syncQ[s] <= 1'b0;
          else          syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // Release flop: waits for the control edge just before a system-clock rise.
  always_ff @(posedge ctlClk or negedge extRstN) begin
    if (!extRstN)                                relQ <= 1'b0;
    else if (syncQ[SYNC_STAGES-1] && strobe.preRise) relQ <= 1'b1;
  end

  assign sysClk  = sysClkQ;
  assign sysRstN = relQ;

  // Checker: control edges spent waiting for release since extRstN rose.
  logic [LAT_W-1:0] waitCnt;
  always_ff @(posedge ctlClk or negedge extRstN) begin
    if (!extRstN)                                   waitCnt <= '0;
    else if (!relQ && waitCnt != LAT_W'(LAT_MAX + 1)) waitCnt <= waitCnt + LAT_W'(1);
  end

  AST_SYS_RISE: assert property (@(posedge extClk) disable iff (!extRstN)
    $rose(sysClk) |-> $past(strobe.preRise)); // R2

  AST_REL_ALIGN: assert property (@(posedge ctlClk) disable iff (!extRstN)
    $rose(sysRstN) |-> $past(strobe.preRise)); // R5

  AST_REL_LATENCY: assert property (@(posedge ctlClk) disable iff (!extRstN)
    waitCnt <= LAT_W'(LAT_MAX)); // R6

  AST_REL_AFTER_INPUT: assert property (@(posedge ctlClk) disable iff (!extRstN)
    $rose(sysRstN) |-> $past(extRstN, 2)); // R5

endmodule

// File: rtl/clkRstGen.sv
module clkRstGen
  import clkrst_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic extClk,
  input  logic extRstN,
  output logic ctlClk,
  output logic sysClk,
  output logic sysRstN
);

  divStrobe_t strobe;

  divCtrl #(
    .DIV_RATIO (DIV_RATIO)
  ) u_ctrl (
    .extClk  (extClk),
    .extRstN (extRstN),
    .strobe  (strobe)
  );

  clkRstPath #(
    .DIV_RATIO   (DIV_RATIO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_path (
    .extClk  (extClk),
    .extRstN (extRstN),
    .strobe  (strobe),
    .ctlClk  (ctlClk),
    .sysClk  (sysClk),
    .sysRstN (sysRstN)
  );

endmodule

// File: tb/sim_clkRstGen.sv
`timescale 1ns/1ps
module sim_clkRstGen;

  localparam int DIV  = 3;
  localparam int SYNC = 2;

  logic extClk = 1'b0;
  logic extRstN = 1'b0;
  logic ctlClk, sysClk, sysRstN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  clkRstGen #(.DIV_RATIO(DIV), .SYNC_STAGES(SYNC)) u0 (
    .extClk(extClk), .extRstN(extRstN),
    .ctlClk(ctlClk), .sysClk(sysClk), .sysRstN(sysRstN)
  );

  always #10 extClk = ~extClk;  // 50 MHz

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Expected system clock after p extClk rising edges since release (R2, R4).
  function automatic bit expSys(input int p);
    return (p % DIV) == (DIV - 1);
  endfunction

  // Release allowed on this control edge (R5): n control edges, p extClk rises so far.
  function automatic bit relEdge(input int n, input int p);
    return (n >= SYNC + 1) && ((p % DIV) == (DIV - 2));
  endfunction

  function automatic int pickOffset();
    int o = 2 + int'($urandom % 7);       // 2..8
    if ($urandom % 2) o = o + 10;         // 12..18
    return o;
  endfunction

  task automatic releaseAndTrack(input int off);
    int pos = 0;
    int neg = 0;
    bit rel = 1'b0;
    int relAt = 0;
    @(posedge extClk);
    #(off);
    extRstN = 1'b1;
    for (int h = 0; h < 40; h++) begin
      @(extClk);
      #2;
      check(ctlClk === ~extClk, "R1", int'(ctlClk), int'(~extClk));
      if (extClk) begin
        pos++;
      end else begin
        neg++;
        if (!rel && relEdge(neg, pos)) begin
          rel = 1'b1;
          relAt = neg;
        end
        check(sysRstN === rel, "R5", int'(sysRstN), int'(rel));
      end
      check(sysClk === expSys(pos), "R4", int'(sysClk), int'(expSys(pos)));
    end
    check(rel && relAt <= SYNC + DIV, "R6", relAt, SYNC + DIV);
  endtask

  task automatic dropReset(input int off, input int holdCycles);
    @(posedge extClk);
    #(off);
    extRstN = 1'b0;
    #1;
    check(sysRstN === 1'b0, "R3", int'(sysRstN), 0);  // no clock edge yet
    for (int c = 0; c < holdCycles; c++) begin
      @(posedge extClk);
      #2;
      check(sysClk === 1'b0 && sysRstN === 1'b0, "R3", int'({sysClk, sysRstN}), 0);
      check(ctlClk === ~extClk, "R1", int'(ctlClk), int'(~extClk));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // Reset state.
    #5;
    check(sysRstN === 1'b0, "R3", int'(sysRstN), 0);
    repeat (3) begin
      @(posedge extClk);
      #2;
      check(sysClk === 1'b0, "R3", int'(sysClk), 0);
    end
    // Directed: release in the high half, then in the low half (R4, R5).
    releaseAndTrack(5);
    dropReset(7, 2);
    releaseAndTrack(15);
    // Long run: R2 period over many cycles.
    begin
      int rises = 0;
      int prevRise = -1;
      bit last = sysClk;
      for (int k = 0; k < 60; k++) begin
        @(posedge extClk);
        #2;
        if (sysClk && !last) begin
          if (prevRise >= 0) check(k - prevRise == DIV, "R2", k - prevRise, DIV);
          prevRise = k;
          rises++;
        end
        last = sysClk;
      end
      check(rises == 20, "R2", rises, 20);
    end
    // Random mid-run resets (R7).
    for (int t = 0; t < 30; t++) begin
      dropReset(pickOffset(), 1 + int'($urandom % 4));
      releaseAndTrack(pickOffset());  // R7: sequence restarts identically
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule